// File: doc/BRIEF.md
# Programmable Pulse and Delay Timer

This block is a cycle-based model of a programmable timing element with two modes. In delay mode the trigger input passes through a tapped shift line. The main output takes its copy at a tap chosen by an 8-bit code. The pulse output takes its copy at a fixed tap that acts as a reference latency.

In one-shot mode a rising edge on the trigger starts a single pulse on the pulse output. The pulse begins once the reference latency has elapsed and ends once the programmed code has elapsed. A trigger edge that arrives during the pulse is ignored. In this mode the main output gives an inverted, delayed copy of the trigger. Wiring it back to the trigger input therefore produces a square wave whose period is set by the code. Driving the trigger from a free-running clock instead gives a pulse-width modulated output whose duty follows the code.

Time is counted in clock cycles. The parameter `REF_LAT` sets the reference latency. The parameter `CODE_W` sets the code width, and the shift line is `2**CODE_W` stages deep.

Top module: `tpe_pulse_timer`

## Requirements
- R1: With `mode_sel` = 0, `pwm_out` in cycle c equals the value `trig_in` held in cycle c − `REF_LAT`.
- R2: With `mode_sel` = 0, `main_out` in cycle c equals the value `trig_in` held in cycle c − (`code` + 1), with no inversion.
- R3: With `mode_sel` = 1, a rising trigger edge is taken on the first clock edge E at which `trig_in` is 1 after being 0. `pwm_out` goes high `REF_LAT` cycles after E.
- R4: With `mode_sel` = 1, `pwm_out` returns low `code` cycles after E, so the pulse is `code` − `REF_LAT` cycles wide.
- R5: A pulse occupies the block until `max(code, REF_LAT)` cycles after E. A rising trigger edge taken during that span, including exactly at its last edge, starts no pulse. A rising edge taken later starts a new pulse.
- R6: If `code` ≤ `REF_LAT`, a trigger produces no pulse and `pwm_out` stays low.
- R7: With `mode_sel` = 1, `main_out` in cycle c equals the inverse of the value `trig_in` held in cycle c − (`code` + 1).
- R8: With `mode_sel` = 1 and `main_out` fed back to `trig_in`, `main_out` toggles with a period of 2·(`code` + 1) cycles.
- R9: The code is captured when a pulse starts. Changing `code` during a pulse does not change that pulse's width.
- R10: While `rst_n` is low, `pwm_out` is 0 and `main_out` equals `mode_sel`.
- R11: A trigger held high starts exactly one pulse. A new pulse needs the trigger to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = delay mode, 1 = one-shot mode |
| trig_in | input | 1 | Signal to delay / one-shot trigger |
| code | input | CODE_W | Programmed delay in cycles |
| pwm_out | output | 1 | Reference copy (mode 0) or one-shot pulse (mode 1) |
| main_out | output | 1 | Delayed trigger, inverted in mode 1 |

## Verification
The bench builds the block with `CODE_W` = 6 and `REF_LAT` = 3. This gives a 64-stage line, so the longest tap, code 63, is reached in a short run. With a small reference latency, codes below, equal to and one above the latency are all cheap to visit. These are the zero-width and single-cycle pulse boundaries. The bench also places a retrigger exactly on the last busy edge and closes the feedback loop for two codes to measure the oscillation period.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

  typedef enum logic {
    MODE_DELAY   = 1'b0,
    MODE_ONESHOT = 1'b1
  } tpe_mode_e;

  function automatic int tpe_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tpe_edge_stage.sv
module tpe_edge_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic lvl_q;
  logic lvl_d;

  assign lvl_d = sig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign rise_o = sig_i & ~lvl_q;

  // R11: a level held high yields one rise indication only
  p_single_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tpe_tap_line.sv
module tpe_tap_line #(
  parameter int SEL_W   = 8,
  parameter int FIX_TAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sel_tap_o,
  output logic             fix_tap_o
);

  localparam int DEPTH = 1 << SEL_W;

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      assign stage_d[gi] = din_i;
    end else begin : g_body
      assign stage_d[gi] = stage_q[gi-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sel_tap_o = stage_q[sel_i];
  assign fix_tap_o = stage_q[FIX_TAP-1];

endmodule

// File: rtl/tpe_oneshot.sv
module tpe_oneshot
  import tpe_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int REF_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);

  localparam int CNT_W = $clog2(tpe_max(1 << CODE_W, REF_LAT) + 1);
  localparam logic [CNT_W-1:0] REF_C = CNT_W'(REF_LAT);

  logic              busy_q, busy_d;
  logic              pulse_q, pulse_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] lim_q, lim_d;
  logic              start, cnt_en, lim_en;
  logic [CNT_W-1:0]  lim_ext, lim_act, end_act;

  // next-state logic
  always_comb begin
    lim_ext = CNT_W'(lim_q);
    start   = en_i & rise_i & ~busy_q;
    cnt_en  = start | busy_q;
    lim_en  = start;
    lim_d   = code_i;
    lim_act = start ? CNT_W'(code_i) : lim_ext;
    end_act = (lim_act > REF_C) ? lim_act : REF_C;
    cnt_d   = start ? '0 : (cnt_q + CNT_W'(1));
    busy_d  = cnt_en & (cnt_d < end_act);
    pulse_d = en_i & cnt_en & (cnt_d >= REF_C) & (cnt_d < lim_act);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_d;
  end

  assign pulse_o = pulse_q;

  // R3: the pulse starts exactly at the reference latency
  p_ref_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> (cnt_q == REF_C));

  // R4: the pulse never outlasts the captured code
  p_fall_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cnt_q < CNT_W'(lim_q)));

  // R5: while occupied the count only advances, never restarts
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R6: a code at or below the latency gives no pulse
  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(lim_q) <= REF_C) |-> !pulse_q);

  // R9: the captured code holds for the whole pulse
  p_lim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && busy_q) |-> $stable(lim_q));

endmodule

// File: rtl/tpe_pulse_timer.sv
module tpe_pulse_timer
  import tpe_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int REF_LAT = 4   // 1 .. 2**CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              trig_in,
  input  logic [CODE_W-1:0] code,
  output logic              pwm_out,
  output logic              main_out
);

  tpe_mode_e mode;
  logic      trig_rise;
  logic      pulse;
  logic      sel_tap;
  logic      fix_tap;

  assign mode = tpe_mode_e'(mode_sel);

  tpe_edge_stage u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (trig_in),
    .rise_o (trig_rise)
  );

  tpe_tap_line #(
    .SEL_W   (CODE_W),
    .FIX_TAP (REF_LAT)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_i     (trig_in),
    .sel_i     (code),
    .sel_tap_o (sel_tap),
    .fix_tap_o (fix_tap)
  );

  tpe_oneshot #(
    .CODE_W  (CODE_W),
    .REF_LAT (REF_LAT)
  ) u_shot (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (mode == MODE_ONESHOT),
    .rise_i  (trig_rise),
    .code_i  (code),
    .pulse_o (pulse)
  );

  assign pwm_out  = (mode == MODE_ONESHOT) ? pulse : fix_tap;
  assign main_out = sel_tap ^ (mode == MODE_ONESHOT);

endmodule

// File: tb/sim_tpe_pulse_timer.sv
module sim_tpe_pulse_timer;

  localparam int CW = 6;
  localparam int RL = 3;

  typedef struct {
    int    at;
    bit    sel;   // 0 = pwm_out, 1 = main_out
    bit    val;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic          drv = 1'b0;
  logic          osc = 1'b0;
  logic [CW-1:0] code = '0;
  logic          pwm_out, main_out;
  logic          trig;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  item_t sb[$];

  assign trig = osc ? main_out : drv;

  tpe_pulse_timer #(.CODE_W(CW), .REF_LAT(RL)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .trig_in(trig),
    .code(code), .pwm_out(pwm_out), .main_out(main_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_at(input int at, input bit sel, input bit val, input string tag);
    item_t it;
    it.at = at; it.sel = sel; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          chk((sb[i].sel ? main_out : pwm_out) == sb[i].val, sb[i].tag,
              int'(sb[i].sel ? main_out : pwm_out), int'(sb[i].val));
          sb.delete(i);
        end
      end
    end
  end

  // driver: one cycle of stimulus, with optional expected items
  task automatic step(input bit v, input bit push);
    @(negedge clk);
    drv = v;
    if (push) begin
      if (!mode) begin
        expect_at(cyc + RL, 1'b0, v, "R1");
        expect_at(cyc + int'(code) + 1, 1'b1, v, "R2");
      end else begin
        expect_at(cyc + int'(code) + 1, 1'b1, ~v, "R7");
      end
    end
  endtask

  task automatic drive_for(input bit v, input int n, input bit push);
    repeat (n) step(v, push);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input bit push, output int e);
    step(1'b0, push);
    step(1'b1, push);
    e = cyc + 1;
  endtask

  task automatic pulse_expect(input int e, input int c, input string tag);
    int last;
    last = ((c > RL) ? c : RL) + 3;
    for (int k = 0; k <= last; k++)
      expect_at(e + k, 1'b0, (k >= RL) && (k < c), tag);
  endtask

  task automatic osc_measure(input int c);
    int last, n, span;
    bit prev;
    last = -1; n = 0; prev = main_out;
    span = 12 * (c + 1);
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      if (main_out && !prev) begin
        if (last >= 0) begin
          n++;
          if (n >= 2) chk((cyc - last) == 2 * (c + 1), "R8 period", cyc - last, 2 * (c + 1));
        end
        last = cyc;
      end
      prev = main_out;
    end
    chk(n >= 3, "R8 toggling", n, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e;
    int codes[5];
    codes = '{10, RL + 1, RL, 1, 0};

    // R10: reset state in both modes
    idle(3);
    chk(pwm_out == 1'b0, "R10 pwm in reset", int'(pwm_out), 0);
    chk(main_out == 1'b0, "R10 main in reset mode 0", int'(main_out), 0);
    mode = 1'b1;
    #1;
    chk(main_out == 1'b1, "R10 main in reset mode 1", int'(main_out), 1);
    chk(pwm_out == 1'b0, "R10 pwm in reset mode 1", int'(pwm_out), 0);
    mode = 1'b0;
    idle(1);
    rst_n = 1'b1;

    // R1, R2: delay mode with several codes and patterns
    code = 6'd5;
    for (int i = 0; i < 40; i++) step(((i * 7) % 5) < 2, 1'b1);
    drive_for(1'b0, 4, 1'b1);
    idle(12);
    code = 6'd0;
    for (int i = 0; i < 20; i++) step(i[0] ^ i[2], 1'b1);
    idle(8);
    code = 6'd63;
    for (int i = 0; i < 80; i++) step(((i * 3) % 7) > 3, 1'b1);
    drive_for(1'b0, 2, 1'b1);
    idle(70);

    // R3, R4, R6: one-shot widths above, at and below the latency
    mode = 1'b1;
    idle(2);
    for (int j = 0; j < 5; j++) begin
      code = CW'(codes[j]);
      fire(1'b1, e);
      pulse_expect(e, codes[j], (codes[j] > RL) ? "R3 R4 width" : "R6 no pulse");
      drive_for(1'b1, 2, 1'b1);
      drive_for(1'b0, codes[j] + RL + 4, 1'b1);
      idle(codes[j] + 4);
    end

    // R5: retriggers during the pulse and on its last busy edge are ignored
    code = 6'd20;
    fire(1'b1, e);
    pulse_expect(e, 20, "R5");
    for (int k = 24; k <= 35; k++) expect_at(e + k, 1'b0, 1'b0, "R5 ignored retrigger");
    drive_for(1'b1, 3, 1'b1);
    drive_for(1'b0, 3, 1'b1);
    drive_for(1'b1, 5, 1'b1);
    drive_for(1'b0, 8, 1'b1);
    drive_for(1'b1, 10, 1'b1);
    drive_for(1'b0, 5, 1'b1);
    idle(25);
    // R5: a later rise starts a fresh pulse
    fire(1'b1, e);
    pulse_expect(e, 20, "R5 fresh pulse");
    drive_for(1'b0, 30, 1'b1);
    idle(25);

    // R11: trigger held high gives exactly one pulse
    code = 6'd8;
    fire(1'b1, e);
    pulse_expect(e, 8, "R11");
    for (int k = 12; k < 40; k++) expect_at(e + k, 1'b0, 1'b0, "R11 held high");
    drive_for(1'b1, 40, 1'b1);
    drive_for(1'b0, 3, 1'b1);
    idle(12);

    // R9: code change mid-pulse has no effect on that pulse
    code = 6'd12;
    fire(1'b0, e);
    pulse_expect(e, 12, "R9");
    drive_for(1'b1, 2, 1'b0);
    code = 6'd30;
    drive_for(1'b0, 25, 1'b0);
    idle(5);

    // R8: feedback oscillation
    code = 6'd5;
    drv = 1'b0;
    idle(2);
    osc = 1'b1;
    osc_measure(5);
    osc = 1'b0;
    idle(10);
    code = 6'd13;
    idle(20);
    osc = 1'b1;
    osc_measure(13);
    osc = 1'b0;
    idle(40);

    chk(sb.size() == 0, "scoreboard drained (R1 R2 R7)", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule